// File: doc/BRIEF.md
# Clock Request Routing and Output Gating Controller

This block is the control side of a multi-output clock generator. It decides, for every differential pair, every PCI-domain single-ended clock and every CPU pair, whether the clock is passed or parked low. It does not touch the clock waveforms. It produces one enable per output, and the analog drivers use those enables. A simple byte-wide register write port stands in for the serial configuration bus.

Five shared pins can become active-low clock request inputs. Four of them each steer their request to one of two selectable differential pairs. The fifth always controls pair 6. A shared pin only becomes a request input once the output it normally drives has been switched off. Two active-low stop inputs park the PCI-domain and CPU-domain clocks, and the free-running outputs keep toggling. All request and stop inputs pass through a two-flop synchronizer. An enable changes only while its domain's clock is low, so no runt pulse is produced.

Top module: `clkreq_ctrl`

## Requirements
- R1: During and after reset: `pci_oe` = 2'b11, `req_dir` = 0 and every enable output is 0. At the first clock edge after reset release with all phase inputs low, `src_en` = 9'h1FF, `pci_en` = 6'h3F and `cpu_en` = 3'h7.
- R2: Register writes take effect at the clock edge where `wr_en` is high. The fields are:
  - address 2, bit 0 / bit 1: PCI0 / PCI1 output enable, reset 1.
  - address 3, bit 3: pair 7 output enable, reset 1.
  - address 4, bit 7: pair 3 output enable, reset 1.
  - address 5: one {enable, select} bit pair per request. Bits 7/6 are request A, 5/4 are B, 3/2 are C and 1/0 are D. All reset 0.
  - address 6, bit 7: request E enable, reset 0.

  Writes to any other address change nothing. A PCI output whose output enable is 0 has its `pci_en` bit at 0.
- R3: Routing of an active request:
  - A and C steer to pair 0 when their select bit is 0 and to pair 2 when it is 1.
  - B and D steer to pair 1 when their select bit is 0 and to pair 4 when it is 1.
  - E controls pair 6.

  A synchronized request level of 1 stops the target pair and a level of 0 lets it run. `req_dir` bits 0..4 (A..E) are 1 exactly when that pin is an active request input.
- R4: A request is active only when its enable bit is 1 and the output enable of its own pin is 0. A uses address 2 bit 0, B uses address 2 bit 1, C and D use address 4 bit 7, and E uses address 3 bit 3. Otherwise the request is ignored and its pin stays an output.
- R5: When several active requests target one pair, the pair runs only if all of them are low.
- R6: While `pci_stop_n` is low, `pci_en[4:0]` are 0 and `pci_en[5]` (free-running) stays 1.
- R7: While `cpu_stop_n` is low, `cpu_en[0]` and `cpu_en[2]` are 0 and `cpu_en[1]` (free-running) stays 1.
- R8: Each enable group changes only at a clock edge where its phase input is 0. `src_phase` covers `src_en`, `pci_phase` covers `pci_en` and `cpu_phase` covers `cpu_en`. While the phase input is 1 the group holds its value.
- R9: With its phase input held at 0, a change on a request or stop input appears at the third rising clock edge after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| req_n | input | 5 | Raw request pins A..E, active low |
| pci_stop_n | input | 1 | Raw PCI-domain stop, active low |
| cpu_stop_n | input | 1 | Raw CPU-domain stop, active low |
| src_phase | input | 1 | Level of the differential-pair source clock |
| pci_phase | input | 1 | Level of the PCI-domain source clock |
| cpu_phase | input | 1 | Level of the CPU-domain source clock |
| src_en | output | 9 | Run enable per differential pair 0..8 |
| pci_en | output | 6 | Run enable per PCI clock 0..5 |
| cpu_en | output | 3 | Run enable per CPU pair 0..2 |
| req_dir | output | 5 | 1 = shared pin A..E acts as request input |
| pci_oe | output | 2 | Driver enable of the PCI0 / PCI1 pins |

## Verification
Two situations are hard to reach from the ports. The first is two enabled requests landing on the same pair. Reaching it takes a configuration where the pins of both A and C have had their own outputs switched off, with both select bits pointing at pair 2. The bench then toggles the two request pins one at a time. The second is a request that changes while its domain's clock is high. The bench holds `src_phase` at 1 for several cycles after moving a request, which lets the synchronized value settle. It then drops the phase and confirms that the enable moves on exactly the next edge.

// File: rtl/ckrq_pkg.sv
package ckrq_pkg;
  localparam int NUM_PAIRS = 9;
  localparam int NUM_PCI   = 6;
  localparam int NUM_CPU   = 3;
  localparam int NUM_REQ   = 5;
  localparam int NUM_STEER = 4;
  localparam int PCI_FREE  = 5;
  localparam int CPU_FREE  = 1;
  localparam int PAIR_C_D  = 3;
  localparam int PAIR_E_PIN = 7;
  localparam int PAIR_E_TGT = 6;

  localparam logic [2:0] ADDR_PCI_OE = 3'd2;
  localparam logic [2:0] ADDR_P7_OE  = 3'd3;
  localparam logic [2:0] ADDR_P3_OE  = 3'd4;
  localparam logic [2:0] ADDR_ROUTE  = 3'd5;
  localparam logic [2:0] ADDR_REQE   = 3'd6;

  typedef struct packed {
    logic [1:0]           pci_oe;
    logic                 p7_oe;
    logic                 p3_oe;
    logic [NUM_STEER-1:0] req_en;
    logic [NUM_STEER-1:0] req_sel;
    logic                 reqe_en;
  } cfg_t;

  // Steered request r: even index -> pair 0/2, odd index -> pair 1/4
  function automatic logic [3:0] steer_target(input int r, input logic sel);
    if (r % 2 == 0) return sel ? 4'd2 : 4'd0;
    else            return sel ? 4'd4 : 4'd1;
  endfunction
endpackage

// File: rtl/ckrq_cfg.sv
module ckrq_cfg
  import ckrq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [2:0] wr_addr_i,
  input  logic [7:0] wr_data_i,
  output cfg_t       cfg_o
);
  cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en_i) begin
      unique case (wr_addr_i)
        ADDR_PCI_OE: cfg_d.pci_oe = wr_data_i[1:0];
        ADDR_P7_OE:  cfg_d.p7_oe  = wr_data_i[3];
        ADDR_P3_OE:  cfg_d.p3_oe  = wr_data_i[7];
        ADDR_ROUTE: begin
          for (int r = 0; r < NUM_STEER; r++) begin
            cfg_d.req_en[r]  = wr_data_i[7-2*r];
            cfg_d.req_sel[r] = wr_data_i[6-2*r];
          end
        end
        ADDR_REQE:   cfg_d.reqe_en = wr_data_i[7];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q.pci_oe  <= 2'b11;
      cfg_q.p7_oe   <= 1'b1;
      cfg_q.p3_oe   <= 1'b1;
      cfg_q.req_en  <= '0;
      cfg_q.req_sel <= '0;
      cfg_q.reqe_en <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/ckrq_sync.sv
module ckrq_sync #(
  parameter int         WIDTH  = 1,
  parameter int         STAGES = 2,
  parameter logic       RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = d_i;
    end else begin : g_next
      assign stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= {WIDTH{RST_VAL}};
      else         stage_q[s] <= stage_d;
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/ckrq_gate.sv
module ckrq_gate #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             phase_i,
  input  logic [WIDTH-1:0] run_i,
  output logic [WIDTH-1:0] en_o
);
  logic [WIDTH-1:0] en_q, en_d;
  logic             upd;

  assign upd = !phase_i;

  always_comb begin
    en_d = en_q;
    if (upd) en_d = run_i;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) en_q <= '0;
    else         en_q <= en_d;
  end

  assign en_o = en_q;

  a_r8_hold_while_high: assert property (@(posedge clk) disable iff (!rst_ni)
    phase_i |=> $stable(en_o));
endmodule

// File: rtl/clkreq_ctrl.sv
module clkreq_ctrl
  import ckrq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [2:0]           wr_addr,
  input  logic [7:0]           wr_data,
  input  logic [NUM_REQ-1:0]   req_n,
  input  logic                 pci_stop_n,
  input  logic                 cpu_stop_n,
  input  logic                 src_phase,
  input  logic                 pci_phase,
  input  logic                 cpu_phase,
  output logic [NUM_PAIRS-1:0] src_en,
  output logic [NUM_PCI-1:0]   pci_en,
  output logic [NUM_CPU-1:0]   cpu_en,
  output logic [NUM_REQ-1:0]   req_dir,
  output logic [1:0]           pci_oe
);
  localparam int SYNC_W = NUM_REQ + 2;

  cfg_t                 cfg;
  logic [SYNC_W-1:0]    raw_in, sync_out;
  logic [NUM_REQ-1:0]   req_s;
  logic                 pci_stop_s, cpu_stop_s;
  logic [NUM_REQ-1:0]   req_act;
  logic [NUM_PAIRS-1:0] src_run;
  logic [NUM_PCI-1:0]   pci_run;
  logic [NUM_CPU-1:0]   cpu_run;

  ckrq_cfg i_cfg (
    .clk(clk), .rst_ni(rst_n), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .cfg_o(cfg)
  );

  assign raw_in = {cpu_stop_n, pci_stop_n, req_n};

  ckrq_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync (
    .clk(clk), .rst_ni(rst_n), .d_i(raw_in), .q_o(sync_out)
  );

  assign req_s      = sync_out[NUM_REQ-1:0];
  assign pci_stop_s = sync_out[NUM_REQ];
  assign cpu_stop_s = sync_out[NUM_REQ+1];

  // A shared pin turns into a request input only once its own output is off
  assign req_act[0] = cfg.req_en[0] & ~cfg.pci_oe[0];
  assign req_act[1] = cfg.req_en[1] & ~cfg.pci_oe[1];
  assign req_act[2] = cfg.req_en[2] & ~cfg.p3_oe;
  assign req_act[3] = cfg.req_en[3] & ~cfg.p3_oe;
  assign req_act[4] = cfg.reqe_en   & ~cfg.p7_oe;

  always_comb begin
    src_run = '1;
    src_run[PAIR_C_D]   = cfg.p3_oe;
    src_run[PAIR_E_PIN] = cfg.p7_oe;
    for (int r = 0; r < NUM_STEER; r++) begin
      if (req_act[r] && req_s[r])
        src_run[steer_target(r, cfg.req_sel[r])] = 1'b0;
    end
    if (req_act[4] && req_s[4]) src_run[PAIR_E_TGT] = 1'b0;
  end

  for (genvar k = 0; k < NUM_PCI; k++) begin : g_pci
    if (k == PCI_FREE) begin : g_free
      assign pci_run[k] = 1'b1;
    end else if (k < 2) begin : g_shared
      assign pci_run[k] = pci_stop_s & cfg.pci_oe[k];
    end else begin : g_plain
      assign pci_run[k] = pci_stop_s;
    end
  end

  for (genvar k = 0; k < NUM_CPU; k++) begin : g_cpu
    if (k == CPU_FREE) begin : g_free
      assign cpu_run[k] = 1'b1;
    end else begin : g_stop
      assign cpu_run[k] = cpu_stop_s;
    end
  end

  ckrq_gate #(.WIDTH(NUM_PAIRS)) i_gate_src (
    .clk(clk), .rst_ni(rst_n), .phase_i(src_phase), .run_i(src_run), .en_o(src_en)
  );
  ckrq_gate #(.WIDTH(NUM_PCI)) i_gate_pci (
    .clk(clk), .rst_ni(rst_n), .phase_i(pci_phase), .run_i(pci_run), .en_o(pci_en)
  );
  ckrq_gate #(.WIDTH(NUM_CPU)) i_gate_cpu (
    .clk(clk), .rst_ni(rst_n), .phase_i(cpu_phase), .run_i(cpu_run), .en_o(cpu_en)
  );

  assign req_dir = req_act;
  assign pci_oe  = cfg.pci_oe;

  a_r4_pin_single_role_a: assert property (@(posedge clk) disable iff (!rst_n)
    req_dir[0] |-> !pci_oe[0]);
  a_r4_pin_single_role_b: assert property (@(posedge clk) disable iff (!rst_n)
    req_dir[1] |-> !pci_oe[1]);
  a_r6_free_pci_never_parks: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(pci_en[PCI_FREE]));
  a_r7_free_cpu_never_parks: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(cpu_en[CPU_FREE]));
  a_r6_stopped_pci_parked: assert property (@(posedge clk) disable iff (!rst_n)
    (!pci_stop_s && !pci_phase) |=> (pci_en[4:0] == 5'b0));
endmodule

// File: tb/test_clkreq_ctrl.sv
module test_clkreq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [2:0] wr_addr;
  logic [7:0] wr_data;
  logic [4:0] req_n;
  logic       pci_stop_n, cpu_stop_n;
  logic       src_phase, pci_phase, cpu_phase;
  logic [8:0] src_en;
  logic [5:0] pci_en;
  logic [2:0] cpu_en;
  logic [4:0] req_dir;
  logic [1:0] pci_oe;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  clkreq_ctrl i_clkreq_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .req_n(req_n), .pci_stop_n(pci_stop_n), .cpu_stop_n(cpu_stop_n),
    .src_phase(src_phase), .pci_phase(pci_phase), .cpu_phase(cpu_phase),
    .src_en(src_en), .pci_en(pci_en), .cpu_en(cpu_en), .req_dir(req_dir), .pci_oe(pci_oe)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    cyc(1);
    wr_en = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 pci_oe in reset", 16'(pci_oe), 16'h3);
    chk("R1 req_dir in reset", 16'(req_dir), 16'h0);
    chk("R1 src_en in reset", 16'(src_en), 16'h0);
    rst_n = 1'b1;
    cyc(1);
    chk("R1 src_en first edge", 16'(src_en), 16'h1FF);
    chk("R1 pci_en first edge", 16'(pci_en), 16'h3F);
    chk("R1 cpu_en first edge", 16'(cpu_en), 16'h7);
  endtask

  task automatic t_ignored_request;
    wr(3'd5, 8'h80);
    req_n[0] = 1'b1;
    cyc(4);
    chk("R4 request A ignored while PCI0 drives", 16'(src_en), 16'h1FF);
    chk("R4 pin A stays output", 16'(req_dir), 16'h0);
  endtask

  task automatic t_routing;
    wr(3'd2, 8'h00);
    cyc(4);
    chk("R2 PCI0/1 output enables cleared", 16'(pci_oe), 16'h0);
    chk("R2 PCI0/1 clocks parked", 16'(pci_en), 16'h3C);
    chk("R3 A high stops pair 0", 16'(src_en), 16'h1FE);
    chk("R3 pin A is input", 16'(req_dir), 16'h01);
    req_n[0] = 1'b0; cyc(4);
    chk("R3 A low runs pair 0", 16'(src_en), 16'h1FF);
    wr(3'd5, 8'hC0); req_n[0] = 1'b1; cyc(4);
    chk("R3 A select 1 stops pair 2", 16'(src_en), 16'h1FB);
    wr(3'd5, 8'h30); req_n[1] = 1'b1; cyc(4);
    chk("R3 B select 1 stops pair 4", 16'(src_en), 16'h1EF);
    chk("R3 only pin B is input", 16'(req_dir), 16'h02);
    wr(3'd4, 8'h00); wr(3'd5, 8'h0A);
    req_n[2] = 1'b1; req_n[3] = 1'b0; cyc(4);
    chk("R3 C to pair 0, D low, pair 3 off", 16'(src_en), 16'h1F6);
    chk("R3 pins C and D inputs", 16'(req_dir), 16'h0C);
    wr(3'd3, 8'h00); wr(3'd6, 8'h80); req_n[4] = 1'b1; cyc(4);
    chk("R3 E stops pair 6, pair 7 off", 16'(src_en), 16'h136);
    chk("R3 pins C, D, E inputs", 16'(req_dir), 16'h1C);
    req_n = 5'b00000; cyc(4);
    chk("R3 all requests low", 16'(src_en), 16'h177);
  endtask

  task automatic t_shared_pair;
    wr(3'd5, 8'hCC);
    req_n[0] = 1'b0; req_n[2] = 1'b1; cyc(4);
    chk("R5 C high alone stops pair 2", 16'(src_en), 16'h173);
    req_n[0] = 1'b1; req_n[2] = 1'b0; cyc(4);
    chk("R5 A high alone stops pair 2", 16'(src_en), 16'h173);
    req_n[0] = 1'b0; cyc(4);
    chk("R5 both low runs pair 2", 16'(src_en), 16'h177);
  endtask

  task automatic t_bad_address;
    wr(3'd7, 8'hFF); wr(3'd1, 8'hFF); wr(3'd0, 8'hFF);
    cyc(4);
    chk("R2 unmapped writes leave src_en", 16'(src_en), 16'h177);
    chk("R2 unmapped writes leave req_dir", 16'(req_dir), 16'h15);
    chk("R2 unmapped writes leave pci_oe", 16'(pci_oe), 16'h0);
  endtask

  task automatic t_latency;
    req_n[0] = 1'b1;
    cyc(2);
    chk("R9 unchanged after two edges", 16'(src_en[2]), 16'h1);
    cyc(1);
    chk("R9 changed on third edge", 16'(src_en[2]), 16'h0);
  endtask

  task automatic t_phase_hold;
    src_phase = 1'b1;
    req_n[0] = 1'b0;
    cyc(6);
    chk("R8 src_en held while phase high", 16'(src_en[2]), 16'h0);
    src_phase = 1'b0;
    cyc(1);
    chk("R8 src_en updates once phase low", 16'(src_en[2]), 16'h1);
  endtask

  task automatic t_pci_stop;
    pci_stop_n = 1'b0; cyc(4);
    chk("R6 PCI stop parks all but free", 16'(pci_en), 16'h20);
    wr(3'd2, 8'h03); cyc(3);
    chk("R6 PCI stop holds with outputs re-enabled", 16'(pci_en), 16'h20);
    pci_stop_n = 1'b1; cyc(4);
    chk("R6 PCI stop released", 16'(pci_en), 16'h3F);
    pci_phase = 1'b1; pci_stop_n = 1'b0; cyc(5);
    chk("R8 pci_en held while phase high", 16'(pci_en), 16'h3F);
    pci_phase = 1'b0; cyc(1);
    chk("R8 pci_en updates once phase low", 16'(pci_en), 16'h20);
    pci_stop_n = 1'b1; cyc(4);
  endtask

  task automatic t_cpu_stop;
    cpu_stop_n = 1'b0; cyc(4);
    chk("R7 CPU stop keeps only free pair", 16'(cpu_en), 16'h2);
    chk("R7 CPU stop leaves PCI alone", 16'(pci_en), 16'h3F);
    cpu_stop_n = 1'b1; cyc(4);
    chk("R7 CPU stop released", 16'(cpu_en), 16'h7);
  endtask

  initial begin
    #800000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    req_n = 5'b11111; pci_stop_n = 1'b1; cpu_stop_n = 1'b1;
    src_phase = 1'b0; pci_phase = 1'b0; cpu_phase = 1'b0;
    cyc(3);
    t_reset();
    t_ignored_request();
    t_routing();
    t_shared_pair();
    t_bad_address();
    t_latency();
    t_phase_hold();
    t_pci_stop();
    t_cpu_stop();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule